// File: doc/BRIEF.md
# Predicated Set-First Mask Generator

This block turns a source mask into a destination mask by finding the first set source bit, scanning upward from lane 0. It has three modes. Set-before-first marks the lanes below the first set bit. Set-including-first marks those lanes and the first set lane as well. Set-only-first marks the first set lane alone.

A predicate decides which lanes take part. Disabled lanes are skipped when the block searches for the first set bit, and they keep the bit of the old destination mask. When no predicate is supplied, every lane is active.

One request is accepted per cycle through a valid strobe. The result is registered and appears one cycle later with its own valid.

Top module: `setfirst_mask`

## Requirements
- R1: With mode 00 (before-first), an active lane below the lowest active lane whose source bit is 1 gives 1. That lane and every active lane above it give 0.
- R2: With mode 00, if no active lane has a source bit of 1, every active lane gives 1.
- R3: With mode 01 (including-first), the result is the mode 00 result with the first active set lane also at 1. If there is no such lane, every active lane gives 1.
- R4: With mode 10 (only-first), only the lowest active lane whose source bit is 1 gives 1. Every other active lane gives 0, so at most one active lane is 1.
- R5: When `pred_en` is 0, all lanes are active and `pred` has no effect on the result.
- R6: A lane whose `pred` bit is 0 while `pred_en` is 1 is inactive. It outputs its `old_dst` bit and is ignored in the search, even when its source bit is set.
- R7: Mode 11 is reserved. It outputs `old_dst` unchanged.
- R8: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1. The result is on `dst` in that same cycle. `dst` keeps its value while no request is accepted.
- R9: After reset, `out_valid` and `dst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for this cycle |
| mode | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| src | input | LANES | Source mask, lane 0 is bit 0 |
| pred | input | LANES | Predicate, 1 marks an active lane |
| pred_en | input | 1 | 1 applies `pred`, 0 makes all lanes active |
| old_dst | input | LANES | Previous destination mask, kept on inactive lanes |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dst | output | LANES | Registered destination mask |

## Verification
The only state in the block is the output register, so a fault in the scan or the merge appears on `dst` in the cycle after the request. A lane that is wrongly treated as active shows up as a flipped bit where `old_dst` should pass through. A wrong first-set position moves the 1-to-0 boundary by at least one lane. Faults in the valid path or the hold path show up on the following idle cycle, as a stray `out_valid` or a changed `dst`.

// File: rtl/setfirst_mask.sv
module setfirst_mask #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [LANES-1:0] src,
  input  logic [LANES-1:0] pred,
  input  logic             pred_en,
  input  logic [LANES-1:0] old_dst,
  output logic             out_valid,
  output logic [LANES-1:0] dst
);

  localparam logic [LANES-1:0] ONE = LANES'(1);

  logic [LANES-1:0] act, hit, first, below, pick, nxt;

  assign act   = pred_en ? pred : '1;
  assign hit   = src & act;
  assign first = hit & (~hit + ONE);
  assign below = first - ONE;

  always_comb begin
    case (mode)
      2'b00:   pick = below;
      2'b01:   pick = below | first;
      2'b10:   pick = first;
      default: pick = old_dst;
    endcase
  end

  assign nxt = (mode == 2'b11) ? old_dst : ((pick & act) | (old_dst & ~act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst <= nxt;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst));
  assert_reserved_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> dst == $past(old_dst));
  assert_inactive_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((dst ^ $past(old_dst)) & ~$past(act)) == '0);
  assert_single_hot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> $countones(dst & $past(act)) <= 1);
  assert_empty_all_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00 && (src & act) == '0) |=> (dst & $past(act)) == $past(act));

endmodule

// File: tb/setfirst_mask_test.sv
module setfirst_mask_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] src = '0, pred = '0, old_dst = '0;
  logic         pred_en = 1'b0;
  logic         out_valid;
  logic [W-1:0] dst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  setfirst_mask #(.LANES(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .src(src),
    .pred(pred), .pred_en(pred_en), .old_dst(old_dst),
    .out_valid(out_valid), .dst(dst)
  );

  function automatic logic [W-1:0] model(input logic [1:0] m, input logic [W-1:0] s,
                                         input logic [W-1:0] p, input logic pe,
                                         input logic [W-1:0] od);
    logic [W-1:0] r;
    bit found;
    r = od;
    found = 0;
    if (m == 2'b11) return od;
    for (int i = 0; i < W; i++) begin
      if (!pe || p[i]) begin
        if (!found && s[i]) begin
          found = 1;
          r[i] = (m != 2'b00);
        end else if (!found) begin
          r[i] = (m != 2'b10);
        end else begin
          r[i] = 1'b0;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] m, input logic [W-1:0] s,
                     input logic [W-1:0] p, input logic pe, input logic [W-1:0] od,
                     input logic [W-1:0] exp);
    logic [W-1:0] held;
    @(negedge clk);
    in_valid = 1'b1; mode = m; src = s; pred = p; pred_en = pe; old_dst = od;
    @(negedge clk);
    in_valid = 1'b0; src = ~s; old_dst = ~od;
    check({req, " valid"}, W'(out_valid), W'(1));
    check(req, dst, exp);
    check({req, " model"}, dst, model(m, s, p, pe, od));
    held = dst;
    @(negedge clk);
    check("R8 idle valid", W'(out_valid), W'(0));
    check("R8 hold", dst, held);
  endtask

  task automatic t_reset;
    check("R9 valid", W'(out_valid), W'(0));
    check("R9 dst", dst, '0);
  endtask

  task automatic t_unpredicated;
    run("R1 before", 2'b00, 8'b10010100, 8'h00, 1'b0, 8'h00, 8'b00000011);
    run("R3 including", 2'b01, 8'b10010100, 8'h00, 1'b0, 8'h00, 8'b00000111);
    run("R4 only", 2'b10, 8'b10010100, 8'h00, 1'b0, 8'h00, 8'b00000100);
    run("R2 empty", 2'b00, 8'h00, 8'h00, 1'b0, 8'h5A, 8'hFF);
    run("R3 empty", 2'b01, 8'h00, 8'h00, 1'b0, 8'h00, 8'hFF);
    run("R4 empty", 2'b10, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h00);
    run("R1 lane0", 2'b00, 8'h01, 8'h00, 1'b0, 8'hFF, 8'h00);
    run("R4 top", 2'b10, 8'h80, 8'h00, 1'b0, 8'h00, 8'h80);
  endtask

  task automatic t_predicated;
    run("R6 before", 2'b00, 8'b10010100, 8'b11000011, 1'b1, 8'b00111100, 8'b01111111);
    run("R6 before old0", 2'b00, 8'b10010100, 8'b11000011, 1'b1, 8'b00000000, 8'b01000011);
    run("R6 only", 2'b10, 8'b11010100, 8'b11000011, 1'b1, 8'b00000000, 8'b01000000);
    run("R6 including", 2'b01, 8'b00111100, 8'b11000011, 1'b1, 8'b00101000, 8'b11101011);
    run("R5 pred ignored", 2'b00, 8'b00010000, 8'b00000001, 1'b0, 8'hAA, 8'b00001111);
  endtask

  task automatic t_reserved;
    run("R7 reserved", 2'b11, 8'h0F, 8'hF0, 1'b1, 8'h96, 8'h96);
    run("R7 reserved nopred", 2'b11, 8'h00, 8'h00, 1'b0, 8'h3C, 8'h3C);
  endtask

  task automatic t_sweep;
    logic [W-1:0] s, p, od;
    for (int k = 0; k < 40; k++) begin
      s  = W'(k * 37 + 11);
      p  = W'(k * 53 + 7);
      od = W'(k * 29 + 3);
      run("R1 R3 R4 sweep", 2'(k % 3), s, p, k[0], od, model(2'(k % 3), s, p, k[0], od));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_unpredicated;
    t_predicated;
    t_reserved;
    t_sweep;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule